// File: doc/BRIEF.md
# Serial CRC Single-Bit Error Locator

This block receives a fixed-length sector one bit per clock: the data field first, then the stored check bits. It folds every accepted bit into a CRC remainder register. When the last bit of the codeword arrives, that register holds the syndrome. A zero syndrome marks the sector as clean. A nonzero syndrome starts a search. The search does not use a lookup table to find the flipped bit. Instead, it multiplies the syndrome by x once per clock until the register equals the constant x^L mod P, where L is the codeword length. The number of steps taken gives the error position directly. If no match is found within L steps, the sector is reported as uncorrectable.

The search spends clock cycles only when an error was detected. A single-bit error at transmitted index j costs j+1 cycles after the last bit. The block only reports the index. Flipping that bit in a sector buffer is left to the surrounding logic. The polynomial, the check width and the data length are parameters, and the target constant is computed at elaboration. The default configuration uses the 16-bit polynomial 0x1021 over 4096 data bits, which gives a 4112-bit codeword and a 13-bit index.

Top module: `crc_single_bit_locator`

## Requirements
- R1: The remainder register starts at all zeros for each sector and has no final inversion. The codeword is fed most significant bit first, and the check bits follow the data with their most significant bit first. A codeword whose check bits equal the remainder of data·x^CRC_W modulo POLY is reported as done with `err_found`, `corrected` and `uncorrectable` all low.
- R2: For a clean sector, `done` is high directly after the clock edge that accepts the L-th bit.
- R3: When exactly one bit is flipped at transmitted index j (0 = first data bit, L-1 = last check bit), the block reports `err_found`=1 and `corrected`=1, with `err_index`=j.
- R4: For a corrected error at index j, `done` rises j+1 clock edges after the edge that accepted the L-th bit.
- R5: If a nonzero syndrome does not reach x^L mod P within L multiply steps, the block reports `err_found`=1 and `uncorrectable`=1, with `corrected`=0 and `err_index`=0. `done` rises L edges after the last bit.
- R6: `corrected` and `uncorrectable` are never high together. No result flag is high while `done` is low.
- R7: Results stay unchanged until the next `sector_start`. A `sector_start` clears `done` at the next edge.
- R8: A bit presented while `bit_valid` is low is not counted. Valid bits after the L-th bit and before the next `sector_start` are ignored. A `sector_start` that comes with a valid bit counts that bit as index 0.
- R9: After reset, `done`, `err_found`, `corrected`, `uncorrectable` and `err_index` are all zero.
- R10: A sector with two flipped bits is never reported as clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_start | input | 1 | Starts a new sector and clears the previous result |
| bit_valid | input | 1 | `bit_in` carries a codeword bit this cycle |
| bit_in | input | 1 | Serial codeword bit |
| done | output | 1 | Result valid, held until the next sector start |
| err_found | output | 1 | Syndrome was nonzero |
| corrected | output | 1 | One flipped bit was located |
| uncorrectable | output | 1 | Search exhausted without a match |
| err_index | output | $clog2(L) | Index of the flipped bit from the first transmitted bit |

## Verification
The bench is built with a short data field. This keeps the test fast enough to flip every single position of the codeword, including the first data bit and the last check bit. Each flip checks both the reported index and the search latency.

Clean random sectors separate a zero syndrome from a nonzero one. Random double-bit flips are judged against a brute-force flip-and-recheck predictor. This separates a miscorrection from an exhausted search and shows that such a sector never reads as clean.

Gaps with `bit_valid` low and surplus valid bits during the search test whether the bit counter obeys the strobe and the length limit. A mid-hold `sector_start` tests the result clearing.

// File: rtl/crc_loc_pkg.sv
package crc_loc_pkg;

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_DONE} srch_state_e;

  // Mask of the low w bits (w from 1 to 32).
  function automatic logic [31:0] low_mask(int unsigned w);
    return 32'hFFFF_FFFF >> (32 - w);
  endfunction

  // Shift one codeword bit into a remainder register (division form).
  function automatic logic [31:0] crc_shift_in(logic [31:0] s, logic b,
                                               logic [31:0] poly, int unsigned w);
    logic        top;
    logic [31:0] r;
    top = s[w-1];
    r   = ((s << 1) | {31'd0, b}) & low_mask(w);
    if (top) r = r ^ (poly & low_mask(w));
    return r;
  endfunction

  // Multiply a residue by x modulo the polynomial.
  function automatic logic [31:0] mul_x(logic [31:0] s, logic [31:0] poly,
                                        int unsigned w);
    return crc_shift_in(s, 1'b0, poly, w);
  endfunction

  // x^n mod P, evaluated at elaboration.
  function automatic logic [31:0] xpow_mod(int unsigned n, logic [31:0] poly,
                                           int unsigned w);
    logic [31:0] r;
    r = 32'd1;
    for (int unsigned i = 0; i < n; i++) r = mul_x(r, poly, w);
    return r;
  endfunction

endpackage

// File: rtl/crc_loc_syndrome.sv
module crc_loc_syndrome
  import crc_loc_pkg::*;
#(
  parameter int unsigned CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter int unsigned CW_BITS = 4112,
  localparam int unsigned CNT_W  = $clog2(CW_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sos_i,
  input  logic             valid_i,
  input  logic             bit_i,
  output logic             syn_fire_o,
  output logic [CRC_W-1:0] syn_o
);

  logic [CRC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;

  // Named internal events.
  logic [CRC_W-1:0] base_acc;
  logic [CNT_W-1:0] base_cnt;
  logic             take;
  logic [CRC_W-1:0] acc_next;

  assign base_acc = sos_i ? '0 : acc;
  assign base_cnt = sos_i ? '0 : cnt;
  assign take     = valid_i && (base_cnt < CNT_W'(CW_BITS));
  assign acc_next = CRC_W'(crc_shift_in(32'(base_acc), bit_i, 32'(POLY), CRC_W));

  assign syn_fire_o = take && (base_cnt == CNT_W'(CW_BITS - 1));
  assign syn_o      = acc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      acc <= acc_next;
      cnt <= base_cnt + 1'b1;
    end else if (sos_i) begin
      acc <= '0;
      cnt <= '0;
    end
  end

  // Bit counter never runs past the codeword length.
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CW_BITS));

  // An invalid bit leaves the remainder untouched.
  p_gap_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !sos_i) |=> ($stable(acc) && $stable(cnt)));

endmodule

// File: rtl/crc_loc_search.sv
module crc_loc_search
  import crc_loc_pkg::*;
#(
  parameter int unsigned CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter int unsigned CW_BITS = 4112,
  localparam int unsigned CNT_W  = $clog2(CW_BITS + 1),
  localparam int unsigned IDX_W  = $clog2(CW_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sos_i,
  input  logic             syn_fire_i,
  input  logic [CRC_W-1:0] syn_i,
  output logic             done_o,
  output logic             err_o,
  output logic             corr_o,
  output logic             unc_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [CRC_W-1:0] TARGET =
    CRC_W'(xpow_mod(CW_BITS, 32'(POLY), CRC_W));

  srch_state_e      state;
  logic [CRC_W-1:0] s;
  logic [CNT_W-1:0] k;

  // Named internal events.
  logic [CRC_W-1:0] step_val;
  logic [CNT_W-1:0] k_next;
  logic             hit;
  logic             exhausted;

  assign step_val  = CRC_W'(mul_x(32'(s), 32'(POLY), CRC_W));
  assign k_next    = k + 1'b1;
  assign hit       = (state == S_SEARCH) && (step_val == TARGET);
  assign exhausted = (state == S_SEARCH) && !hit && (k_next == CNT_W'(CW_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      s      <= '0;
      k      <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      corr_o <= 1'b0;
      unc_o  <= 1'b0;
      idx_o  <= '0;
    end else if (sos_i) begin
      state  <= S_IDLE;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      corr_o <= 1'b0;
      unc_o  <= 1'b0;
      idx_o  <= '0;
    end else begin
      case (state)
        S_IDLE: if (syn_fire_i) begin
          if (syn_i == '0) begin
            done_o <= 1'b1;
            state  <= S_DONE;
          end else begin
            s     <= syn_i;
            k     <= '0;
            state <= S_SEARCH;
          end
        end
        S_SEARCH: begin
          if (hit) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            corr_o <= 1'b1;
            idx_o  <= IDX_W'(k);
            state  <= S_DONE;
          end else if (exhausted) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            unc_o  <= 1'b1;
            state  <= S_DONE;
          end else begin
            s <= step_val;
            k <= k_next;
          end
        end
        default: ;
      endcase
    end
  end

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(corr_o && unc_o));

  p_flags_need_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o || corr_o || unc_o) |-> done_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !sos_i) |=> (done_o && $stable(idx_o) && $stable(corr_o)
                            && $stable(unc_o) && $stable(err_o)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sos_i |=> !done_o);

  p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEARCH) |-> (k < CNT_W'(CW_BITS)));

  p_unc_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unc_o |-> (idx_o == '0));

  p_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !sos_i && syn_fire_i && syn_i == '0)
      |=> (done_o && !err_o));

endmodule

// File: rtl/crc_single_bit_locator.sv
module crc_single_bit_locator #(
  parameter int unsigned CRC_W     = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter int unsigned DATA_BITS = 4096,
  localparam int unsigned CW_BITS  = DATA_BITS + CRC_W,
  localparam int unsigned IDX_W    = $clog2(CW_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sector_start,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             done,
  output logic             err_found,
  output logic             corrected,
  output logic             uncorrectable,
  output logic [IDX_W-1:0] err_index
);

  logic             syn_fire;
  logic [CRC_W-1:0] syn;

  crc_loc_syndrome #(
    .CRC_W(CRC_W), .POLY(POLY), .CW_BITS(CW_BITS)
  ) u_syn (
    .clk(clk), .rst_n(rst_n), .sos_i(sector_start), .valid_i(bit_valid),
    .bit_i(bit_in), .syn_fire_o(syn_fire), .syn_o(syn)
  );

  crc_loc_search #(
    .CRC_W(CRC_W), .POLY(POLY), .CW_BITS(CW_BITS)
  ) u_search (
    .clk(clk), .rst_n(rst_n), .sos_i(sector_start), .syn_fire_i(syn_fire),
    .syn_i(syn), .done_o(done), .err_o(err_found), .corr_o(corrected),
    .unc_o(uncorrectable), .idx_o(err_index)
  );

endmodule

// File: tb/crc_single_bit_locator_tb.sv
module crc_single_bit_locator_tb_top;

  localparam int unsigned CW    = 16;
  localparam logic [15:0] POLY  = 16'h1021;
  localparam int unsigned DB    = 64;
  localparam int unsigned L     = DB + CW;
  localparam int unsigned IW    = $clog2(L);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sector_start = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic done, err_found, corrected, uncorrectable;
  logic [IW-1:0] err_index;

  int n_chk = 0;
  int n_fail = 0;

  logic cw [L];
  logic rx [L];

  always #10 clk = ~clk;

  crc_single_bit_locator #(.CRC_W(CW), .POLY(POLY), .DATA_BITS(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .sector_start(sector_start),
    .bit_valid(bit_valid), .bit_in(bit_in), .done(done),
    .err_found(err_found), .corrected(corrected),
    .uncorrectable(uncorrectable), .err_index(err_index)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Feedback-register form of the check bits: data * x^16 mod P.
  function automatic logic [15:0] check_of(input bit use_rx);
    logic [15:0] r = '0;
    logic fb;
    for (int j = 0; j < DB; j++) begin
      fb = r[15] ^ (use_rx ? rx[j] : cw[j]);
      r = r << 1;
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  function automatic bit rx_ok();
    logic [15:0] c = check_of(1'b1);
    for (int t = 0; t < CW; t++) if (rx[DB+t] != c[15-t]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic make_sector(input bit zeros);
    logic [15:0] c;
    for (int j = 0; j < DB; j++) cw[j] = zeros ? 1'b0 : 1'($urandom);
    c = check_of(1'b0);
    for (int t = 0; t < CW; t++) cw[DB+t] = c[15-t];
    for (int j = 0; j < L; j++) rx[j] = cw[j];
  endtask

  // Brute-force prediction: kind 0 clean, 1 corrected, 2 uncorrectable.
  task automatic predict(output int kind, output int idx, output int lat);
    kind = 2; idx = 0; lat = L;
    if (rx_ok()) begin kind = 0; lat = 0; return; end
    for (int t = 0; t < L; t++) begin
      rx[t] = ~rx[t];
      if (rx_ok()) begin
        kind = 1; idx = t; lat = t + 1;
        rx[t] = ~rx[t];
        return;
      end
      rx[t] = ~rx[t];
    end
  endtask

  // Sends rx, waits for done; returns edges counted after the last bit.
  task automatic send(input int max_gap, input bit extra, output int n);
    for (int j = 0; j < L; j++) begin
      int g = (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0;
      for (int q = 0; q < g; q++) begin
        @(negedge clk);
        sector_start = 1'b0; bit_valid = 1'b0; bit_in = 1'($urandom);
      end
      @(negedge clk);
      sector_start = (j == 0); bit_valid = 1'b1; bit_in = rx[j];
    end
    @(negedge clk);
    sector_start = 1'b0; bit_valid = extra; bit_in = 1'($urandom);
    n = 0;
    while (!done && n < L + 5) begin
      @(negedge clk);
      bit_in = 1'($urandom);
      n++;
    end
    bit_valid = 1'b0;
  endtask

  task automatic run_one(input string req, input int max_gap, input bit extra);
    int kind, idx, lat, n;
    predict(kind, idx, lat);
    send(max_gap, extra, n);
    chk(done == 1'b1, {req, " done"}, int'(done), 1);
    chk(n == lat, {req, " latency"}, n, lat);
    chk(err_found == (kind != 0), {req, " err_found"}, int'(err_found), int'(kind != 0));
    chk(corrected == (kind == 1), {req, " corrected"}, int'(corrected), int'(kind == 1));
    chk(uncorrectable == (kind == 2), {req, " uncorrectable"}, int'(uncorrectable), int'(kind == 2));
    chk(int'(err_index) == idx, {req, " err_index"}, int'(err_index), idx);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int a, b, n;
    logic [IW-1:0] held;
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!done && !err_found && !corrected && !uncorrectable && err_index == '0,
        "R9 reset outputs", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: clean sectors, zero data and random data
    make_sector(1'b1);
    run_one("R1 R2 clean zero sector", 0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      make_sector(1'b0);
      run_one("R1 R2 clean random sector", 0, 1'b0);
    end

    // R3 R4: every single-bit position
    for (int j = 0; j < L; j++) begin
      make_sector(1'b0);
      rx[j] = ~rx[j];
      run_one("R3 R4 single flip", 0, 1'b0);
    end

    // R10 R5: double flips never clean; outcome matches brute force
    for (int i = 0; i < 25; i++) begin
      make_sector(1'b0);
      a = int'($urandom % L);
      b = (a + 1 + int'($urandom % (L - 1))) % L;
      rx[a] = ~rx[a]; rx[b] = ~rx[b];
      run_one("R10 R5 double flip", 0, 1'b0);
      chk(err_found == 1'b1, "R10 not clean", int'(err_found), 1);
    end

    // R8: valid gaps and surplus bits during the search
    for (int i = 0; i < 4; i++) begin
      make_sector(1'b0);
      a = int'($urandom % L);
      rx[a] = ~rx[a];
      run_one("R8 gaps and surplus bits", 2, 1'b1);
    end

    // R7: result held, then cleared by sector_start
    make_sector(1'b0);
    rx[5] = ~rx[5];
    run_one("R7 setup", 0, 1'b0);
    held = err_index;
    repeat (4) @(negedge clk);
    chk(done && corrected && err_index == held, "R7 held result",
        int'(err_index), int'(held));
    sector_start = 1'b1; bit_valid = 1'b0;
    @(negedge clk);
    sector_start = 1'b0;
    chk(!done && !corrected, "R7 cleared by sector_start", int'(done), 0);

    // R6: exclusive flags after an uncorrectable-or-corrected double flip
    make_sector(1'b0);
    rx[0] = ~rx[0]; rx[L-1] = ~rx[L-1];
    run_one("R6 R10 double flip at both ends", 0, 1'b0);
    chk(!(corrected && uncorrectable), "R6 exclusive flags",
        int'(corrected) + int'(uncorrectable), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule